// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 12-bit successive-approximation conversion against an external comparator. It puts a trial code on the DAC output, reads back one comparator bit per step, and builds the result from the most significant bit down. When the last bit is decided, it stores the code in a result register. A busy status output tells the rest of the system that a conversion is in flight.

A conversion is requested through three control inputs: an active-high enable, an active-low select and an active-low convert line. The request becomes real only when all three are in their active state together. The input that arrives last is the one that triggers the start. The combined request must be held for a minimum number of clock cycles, and a request that stays held starts only one conversion. Once a conversion has started it always runs to the end.

All timing is counted in cycles of the system clock. Parameters set the minimum request width, the delay from start to the rise of busy, the cycles spent on each bit trial, and the margin between latching the result and the fall of busy.

Top module: `sarConvTop`

## Requirements
- R1: A conversion starts when chipEn=1, chipSelN=0 and readConvN=0 have all been sampled together on START_MIN consecutive clock edges. The start edge is the START_MIN-th of these edges, whichever of the three inputs became active last.
- R2: While chipEn=0 or chipSelN=1, no conversion starts: busy stays 0 and result keeps its value, even if the other inputs are held active.
- R3: A combined request held for fewer than START_MIN sampled edges is rejected, and busy stays 0.
- R4: The start clears the decided bits, so dacCode reads 0x800 (only bit 11, the first trial bit, set). busy rises exactly STATUS_DELAY edges after the start edge.
- R5: Bits are tried from bit 11 down to bit 0, BIT_CYCLES edges each. A trial bit is kept when cmpAbove=1 (input at or above dacCode) and cleared otherwise. The result is offset binary: 0x000 for a zero input, 0xFFF for full scale, and it equals the input code.
- R6: result is loaded on the edge after the last trial. busy falls exactly RESULT_MARGIN edges after that, and result is already stable when busy falls.
- R7: A request that completes while a conversion is in progress is ignored, including one that completes on the very edge where busy falls. Such a request neither stops nor restarts the conversion. A request that completes on the next edge is accepted.
- R8: A request held without a break through a whole conversion does not start a second one. The request must be released before another start.
- R9: After reset, busy=0, dacCode=0x000 and result=0x000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| chipEn | input | 1 | Enable, active high |
| chipSelN | input | 1 | Select, active low |
| readConvN | input | 1 | Convert request, active low |
| cmpAbove | input | 1 | Comparator: 1 when the sampled input is at or above dacCode |
| busy | output | 1 | Conversion status, high from STATUS_DELAY after the start until the margin after the result latch |
| dacCode | output | WIDTH | Trial code driven to the DAC |
| result | output | WIDTH | Latched conversion result |

## Verification
Two things can land on the same clock edge: the qualification of a new request finishing, and busy falling at the end of a conversion. The bench forces this case by releasing the convert line during a conversion and driving it active again at a computed point. That point is chosen so the START_MIN-th sample of the new request falls exactly on the busy-fall edge, and in a second run one edge later. In the first run, busy must stay low and result must keep the first conversion's code. In the second run, busy must rise exactly STATUS_DELAY edges after the new start and the new input code must appear in result.

// File: rtl/sarConvPkg.sv
package sarConvPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_TRIAL = 2'd2,
    ST_TAIL  = 2'd3
  } convState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clear;  // reset decided bits, arm MSB trial
    logic keep;   // resolve current trial bit from comparator
    logic latch;  // copy decided code into result
  } convStrobe_t;

endpackage

// File: rtl/sarStartGate.sv
module sarStartGate #(
  parameter int START_MIN = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipEn,
  input  logic chipSelN,
  input  logic readConvN,
  input  logic idle,
  output logic startFire
);

  localparam int QW = $clog2(START_MIN + 1);
  localparam logic [QW-1:0] Q_SAT  = QW'(START_MIN);
  localparam logic [QW-1:0] Q_LAST = QW'(START_MIN - 1);

  logic reqActive;
  logic [QW-1:0] qualCnt;

  assign reqActive = chipEn & ~chipSelN & ~readConvN;

  // counts consecutive active samples, saturates so a held request fires once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qualCnt <= '0;
    end else if (!reqActive) begin
      qualCnt <= '0;
    end else if (qualCnt != Q_SAT) begin
      qualCnt <= qualCnt + 1'b1;
    end
  end

  assign startFire = idle & reqActive & (qualCnt == Q_LAST);

endmodule

// File: rtl/sarConvCtrl.sv
module sarConvCtrl
  import sarConvPkg::*;
#(
  parameter int WIDTH         = 12,
  parameter int STATUS_DELAY  = 20,
  parameter int BIT_CYCLES    = 60,
  parameter int RESULT_MARGIN = 50
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startFire,
  output convStrobe_t strobe,
  output logic        busy,
  output logic        idle
);

  localparam int TMAX = (STATUS_DELAY > BIT_CYCLES)
                        ? ((STATUS_DELAY > RESULT_MARGIN) ? STATUS_DELAY : RESULT_MARGIN)
                        : ((BIT_CYCLES > RESULT_MARGIN) ? BIT_CYCLES : RESULT_MARGIN);
  localparam int TW = $clog2(TMAX + 1);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  localparam logic [TW-1:0] LEAD_END  = TW'(STATUS_DELAY - 1);
  localparam logic [TW-1:0] TRIAL_END = TW'(BIT_CYCLES - 1);
  localparam logic [TW-1:0] TAIL_END  = TW'(RESULT_MARGIN);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WIDTH - 1);

  convState_t state, stateNext;
  logic [TW-1:0] timer, timerNext;
  logic [BW-1:0] bitCnt, bitCntNext;

  always_comb begin
    stateNext  = state;
    timerNext  = timer;
    bitCntNext = bitCnt;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startFire) begin
          strobe.clear = 1'b1;
          stateNext    = ST_LEAD;
          timerNext    = '0;
        end
      end
      ST_LEAD: begin
        if (timer == LEAD_END) begin
          stateNext  = ST_TRIAL;
          timerNext  = '0;
          bitCntNext = '0;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_TRIAL: begin
        if (timer == TRIAL_END) begin
          strobe.keep = 1'b1;
          timerNext   = '0;
          if (bitCnt == LAST_BIT) begin
            stateNext = ST_TAIL;
          end else begin
            bitCntNext = bitCnt + 1'b1;
          end
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      ST_TAIL: begin
        strobe.latch = (timer == '0);
        if (timer == TAIL_END) begin
          stateNext = ST_IDLE;
          timerNext = '0;
        end else begin
          timerNext = timer + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      timer  <= timerNext;
      bitCnt <= bitCntNext;
    end
  end

  assign busy = (state == ST_TRIAL) || (state == ST_TAIL);
  assign idle = (state == ST_IDLE);

endmodule

// File: rtl/sarConvPath.sv
module sarConvPath
  import sarConvPkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  convStrobe_t      strobe,
  input  logic             cmpAbove,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result
);

  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0] decided, decidedNext;
  logic [WIDTH-1:0] trialMask, trialMaskNext;

  // per-bit decision: only the bit under trial takes the comparator value
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign decidedNext[i] = strobe.clear ? 1'b0
                          : (strobe.keep && trialMask[i]) ? cmpAbove
                          : decided[i];
  end

  assign trialMaskNext = strobe.clear ? MSB_ONLY
                       : strobe.keep  ? (trialMask >> 1)
                       : trialMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decided   <= '0;
      trialMask <= '0;
      result    <= '0;
    end else begin
      decided   <= decidedNext;
      trialMask <= trialMaskNext;
      if (strobe.latch) begin
        result <= decided;
      end
    end
  end

  assign dacCode = decided | trialMask;

endmodule

// File: rtl/sarConvTop.sv
module sarConvTop
  import sarConvPkg::*;
#(
  parameter int WIDTH         = 12,
  parameter int START_MIN     = 5,
  parameter int STATUS_DELAY  = 20,
  parameter int BIT_CYCLES    = 60,
  parameter int RESULT_MARGIN = 50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chipEn,
  input  logic             chipSelN,
  input  logic             readConvN,
  input  logic             cmpAbove,
  output logic             busy,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result
);

  logic        startFire;
  logic        idle;
  convStrobe_t strobe;

  sarStartGate #(.START_MIN(START_MIN)) gate_i (
    .clk       (clk),
    .rstN      (rstN),
    .chipEn    (chipEn),
    .chipSelN  (chipSelN),
    .readConvN (readConvN),
    .idle      (idle),
    .startFire (startFire)
  );

  sarConvCtrl #(
    .WIDTH        (WIDTH),
    .STATUS_DELAY (STATUS_DELAY),
    .BIT_CYCLES   (BIT_CYCLES),
    .RESULT_MARGIN(RESULT_MARGIN)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startFire (startFire),
    .strobe    (strobe),
    .busy      (busy),
    .idle      (idle)
  );

  sarConvPath #(.WIDTH(WIDTH)) path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cmpAbove (cmpAbove),
    .dacCode  (dacCode),
    .result   (result)
  );

endmodule

// File: rtl/sarConvChecker.sv
module sarConvChecker
  import sarConvPkg::*;
#(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             chipEn,
  input logic             chipSelN,
  input logic             readConvN,
  input logic             busy,
  input logic [WIDTH-1:0] dacCode,
  input logic [WIDTH-1:0] result,
  input convStrobe_t      strobe
);

  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic reqOn;
  assign reqOn = chipEn & ~chipSelN & ~readConvN;

  assert_start_qualified_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |-> (reqOn && $past(reqOn)));

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |-> (chipEn && !chipSelN));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |-> !busy);

  assert_trial_in_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.keep |-> busy);

  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (dacCode == MSB_ONLY));

  assert_margin_after_latch_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> busy);

  assert_result_settled_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $stable(result));

endmodule

bind sarConvTop sarConvChecker #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .chipEn    (chipEn),
  .chipSelN  (chipSelN),
  .readConvN (readConvN),
  .busy      (busy),
  .dacCode   (dacCode),
  .result    (result),
  .strobe    (strobe)
);

// File: tb/sarConvTop_tb_top.sv
module sarConvTop_tb_top;

  localparam int W   = 12;
  localparam int SMN = 5;
  localparam int SD  = 20;
  localparam int BC  = 60;
  localparam int MG  = 50;

  // {lastSel[1:0], vin[11:0]}; lastSel 0=enable last, 1=select last, 2=convert last, 3=together
  localparam logic [13:0] VECS [8] = '{
    {2'd0, 12'h000}, {2'd1, 12'hFFF}, {2'd2, 12'h800}, {2'd3, 12'h7FF},
    {2'd2, 12'h001}, {2'd0, 12'hA5A}, {2'd1, 12'h5A5}, {2'd3, 12'hFFE}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEn = 1'b0;
  logic chipSelN = 1'b1;
  logic readConvN = 1'b1;
  logic [W-1:0] vinReg = '0;
  logic cmpAbove;
  logic busy;
  logic [W-1:0] dacCode;
  logic [W-1:0] result;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  assign cmpAbove = (vinReg >= dacCode);

  sarConvTop #(
    .WIDTH(W), .START_MIN(SMN), .STATUS_DELAY(SD),
    .BIT_CYCLES(BC), .RESULT_MARGIN(MG)
  ) dut_i (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .chipSelN(chipSelN),
    .readConvN(readConvN), .cmpAbove(cmpAbove), .busy(busy),
    .dacCode(dacCode), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic releaseAll();
    @(negedge clk);
    chipEn = 1'b0; chipSelN = 1'b1; readConvN = 1'b1;
  endtask

  // returns at the negedge where the last input became active
  task automatic startConv(input int lastSel);
    @(negedge clk);
    chipEn    = (lastSel != 0 && lastSel != 3);
    chipSelN  = (lastSel == 1 || lastSel == 3);
    readConvN = (lastSel == 2 || lastSel == 3);
    repeat (3) @(negedge clk);
    chipEn = 1'b1; chipSelN = 1'b0; readConvN = 1'b0;
  endtask

  task automatic runConv(input logic [W-1:0] vin, input int lastSel,
                         input bit holdRc, input string tag);
    vinReg = vin;
    startConv(lastSel);
    repeat (SMN + SD - 1) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R4", {tag, " busy before delay"}, busy, 0);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b1, "R1", {tag, " busy rise edge"}, busy, 1);
    check(dacCode == 12'h800, "R4", {tag, " cleared msb trial"}, dacCode, 12'h800);
    if (!holdRc) readConvN = 1'b1;
    repeat (W * BC) @(posedge clk);
    @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(result == vin, "R5", {tag, " result"}, result, vin);
    check(busy == 1'b1, "R6", {tag, " busy after latch"}, busy, 1);
    repeat (MG - 1) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R6", {tag, " busy before fall"}, busy, 1);
    @(posedge clk); @(negedge clk);
    check(busy == 1'b0, "R6", {tag, " busy fall edge"}, busy, 0);
  endtask

  // n: posedges after the latch before the convert line goes low again
  task automatic boundaryCase(input int n, input bit expectStart);
    vinReg = 12'h3C3;
    startConv(2);
    repeat (SMN + SD) @(posedge clk);
    @(negedge clk);
    readConvN = 1'b1;
    repeat (W * BC + 1) @(posedge clk);
    repeat (n) @(posedge clk);
    @(negedge clk);
    readConvN = 1'b0;
    vinReg = 12'h0F0;
    repeat (MG - n) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R7", "boundary busy fell", busy, 0);
    if (expectStart) begin
      repeat (SD) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R7", "next-edge start delay", busy, 0);
      @(posedge clk); @(negedge clk);
      check(busy == 1'b1, "R7", "next-edge start accepted", busy, 1);
      repeat (W * BC + 1 + MG) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R7", "second conversion done", busy, 0);
      check(result == 12'h0F0, "R7", "second result", result, 12'h0F0);
    end else begin
      repeat (SD + 3 * SMN) @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0, "R7", "same-edge request dropped", busy, 0);
      check(result == 12'h3C3, "R7", "result kept", result, 12'h3C3);
    end
    releaseAll();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R9", "reset busy", busy, 0);
    check(dacCode == '0, "R9", "reset dacCode", dacCode, 0);
    check(result == '0, "R9", "reset result", result, 0);
    rstN = 1'b1;

    // table walk: R1 last-arriving input, R5 codes incl. 0x000 and 0xFFF
    for (int v = 0; v < 8; v++) begin
      runConv(VECS[v][11:0], int'(VECS[v][13:12]), 1'b0, $sformatf("vec%0d", v));
      releaseAll();
    end

    // R2: enable low with others active
    @(negedge clk);
    chipEn = 1'b0; chipSelN = 1'b0; readConvN = 1'b0;
    repeat (SD + 10 * SMN) @(negedge clk);
    check(busy == 1'b0, "R2", "enable low blocks", busy, 0);
    check(result == 12'hFFE, "R2", "result untouched (enable)", result, 12'hFFE);
    // R2: select high with others active
    chipEn = 1'b1; chipSelN = 1'b1;
    repeat (SD + 10 * SMN) @(negedge clk);
    check(busy == 1'b0, "R2", "select high blocks", busy, 0);
    check(result == 12'hFFE, "R2", "result untouched (select)", result, 12'hFFE);
    releaseAll();

    // R3: request one sample short
    @(negedge clk);
    chipEn = 1'b1; chipSelN = 1'b0; readConvN = 1'b0;
    repeat (SMN - 1) @(negedge clk);
    readConvN = 1'b1;
    repeat (SD + 10 * SMN) @(negedge clk);
    check(busy == 1'b0, "R3", "short request rejected", busy, 0);
    releaseAll();

    // R7: requests during conversion are ignored
    fork
      runConv(12'h6B1, 2, 1'b0, "poke");
      begin
        repeat (100) @(posedge clk);
        @(negedge clk); readConvN = 1'b1;
        repeat (3) @(negedge clk); readConvN = 1'b0;
        repeat (4 * SMN) @(negedge clk); readConvN = 1'b1;
      end
    join
    repeat (SD + 3 * SMN) @(negedge clk);
    check(busy == 1'b0, "R7", "no restart after poke", busy, 0);
    releaseAll();

    // R8: request held across the whole conversion
    runConv(12'h2D4, 3, 1'b1, "held");
    repeat (SD + 3 * SMN) @(negedge clk);
    check(busy == 1'b0, "R8", "held request no second start", busy, 0);
    check(result == 12'h2D4, "R8", "held result kept", result, 12'h2D4);
    releaseAll();

    // R7 boundary: qualification lands on busy-fall edge, then one edge later
    boundaryCase(MG - SMN, 1'b0);
    boundaryCase(MG - SMN + 1, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule